// File: doc/BRIEF.md
# Tagged Receive Byte Queue with Error-Gated Service Requests

This block is the receive-side holding queue between a serial frame decoder and the consumer of the received bytes, either a processor or a DMA engine. Every entry holds one data byte and two tag bits. One tag marks the last byte of a frame. The other marks a frame whose checksum failed. The decoder pushes a byte and its tags in one cycle. The consumer sees the oldest entry at the read port and removes it with a pop strobe.

The queue raises a service request when its fill level reaches a programmable threshold. The interrupt line also covers two other conditions: a stored end-of-frame tag and an overrun. The DMA request is held back while any stored entry carries a checksum-error tag, so that software inspects a damaged frame before a DMA transfer moves it on. The block keeps a running count of tagged entries for this, so the gating follows the queue contents exactly.

A byte written while the queue is full is dropped, and a sticky overrun flag is set. Older entries are never overwritten. A synchronous clear, used when the receiver is switched off, empties the queue at once.

Top module: `rxq_tagged_fifo`

## Requirements
- R1: After reset, and in the cycle after `clr` is high, `empty`=1, `full`=0, `level`=0, `ovr_flag`=0, `irq`=0 and `dma_req`=0.
- R2: While `empty`=0, `rd_data`, `rd_eof` and `rd_crcerr` show the oldest stored entry, with no pop needed. A high `rd_en` removes that entry at the clock edge. A high `rd_en` while `empty`=1 has no effect.
- R3: A high `wr_en` while the queue is not full stores `wr_data`, `wr_eof` and `wr_crcerr` as one entry, and `level` goes up by one. Entries are read out in the order they were written.
- R4: A high `wr_en` with `rd_en` low while `full`=1 is discarded, and `level` and the stored entries stay unchanged. `ovr_flag` is then set and stays set until it is cleared. Further writes are dropped in the same way for as long as the queue stays full.
- R5: A write and a pop in the same cycle while `full`=1 both take effect. The oldest entry leaves, the new entry is stored, `full` stays 1, and no overrun is flagged.
- R6: A high `ovr_clr` clears `ovr_flag` at the next edge. If an overrun write happens in that same cycle, the flag stays set.
- R7: The trigger condition is true when `level` is nonzero and `level` >= `trig_lvl`.
- R8: `dma_req` is 1 exactly when the trigger condition holds and no stored entry has its checksum-error tag set. The queue counts tagged entries on every push and pop so that this is exact.
- R9: `irq` = `irq_en` AND (trigger condition OR at least one stored entry with its end-of-frame tag set OR `ovr_flag`).
- R10: `clr` has priority over a write or pop in the same cycle: the queue is empty afterwards and the write is not stored.
- R11: `full` is 1 exactly when `level` equals DEPTH, and `empty` is 1 exactly when `level` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear; empties the queue and clears the overrun flag |
| wr_en | input | 1 | Push strobe from the frame decoder |
| wr_data | input | 8 | Byte to store |
| wr_eof | input | 1 | End-of-frame tag for the byte |
| wr_crcerr | input | 1 | Checksum-error tag for the byte |
| rd_en | input | 1 | Pop strobe from the consumer |
| rd_data | output | 8 | Oldest stored byte |
| rd_eof | output | 1 | End-of-frame tag of the oldest entry |
| rd_crcerr | output | 1 | Checksum-error tag of the oldest entry |
| empty | output | 1 | Queue holds no entries |
| full | output | 1 | Queue holds DEPTH entries |
| level | output | $clog2(DEPTH+1) | Number of stored entries |
| trig_lvl | input | $clog2(DEPTH+1) | Service request threshold |
| irq_en | input | 1 | Interrupt enable |
| ovr_clr | input | 1 | Write-one-to-clear strobe for the overrun flag |
| ovr_flag | output | 1 | Sticky overrun flag |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA service request |

## Verification
A pointer that slips makes the read port show a byte, or a tag, that differs from the expected order, and this is seen on the very next pop. A tag counter that drifts shows up as a `dma_req` or `irq` value that stays wrong after the tagged entry has left. It becomes visible as soon as the queue crosses the threshold with clean data, which in a busy stream is within a few dozen cycles. Faults in the full-queue handling show up as a `level` that changes during a dropped write, an overrun flag missing after such a write, or a flag raised during a simultaneous push and pop. In each case the wrong value appears at the edge that follows the stimulus.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
   localparam int BYTE_W = 8;

   typedef struct packed {
      logic              eof;
      logic              crc_err;
      logic [BYTE_W-1:0] data;
   } rxq_entry_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store
   import rxq_pkg::*;
#(
   parameter int DEPTH = 64,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             push,
   input  logic             pop,
   input  rxq_entry_t       wr_ent,
   output rxq_entry_t       rd_ent,
   output logic [CNT_W-1:0] count
);
   rxq_entry_t       mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("rxq_store: DEPTH must be at least 2");
      end
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2_wrap
         assign wr_nxt = wr_ptr + PTR_W'(1);
         assign rd_nxt = rd_ptr + PTR_W'(1);
      end else begin : g_cmp_wrap
         assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
         assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push && !clr) mem[wr_ptr] <= wr_ent;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (clr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_nxt;
         if (pop)  rd_ptr <= rd_nxt;
         case ({push, pop})
            2'b10:   count <= count + CNT_W'(1);
            2'b01:   count <= count - CNT_W'(1);
            default: count <= count;
         endcase
      end
   end

   assign rd_ent = mem[rd_ptr];

   // R4
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));

   // R3
   level_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop && !clr) |=> (count == $past(count) + CNT_W'(1)));
endmodule

// File: rtl/rxq_tally.sv
module rxq_tally #(
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   input  logic             dec,
   output logic [CNT_W-1:0] cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (clr)        cnt <= '0;
      else if (inc && !dec) cnt <= cnt + CNT_W'(1);
      else if (dec && !inc) cnt <= cnt - CNT_W'(1);
   end

   // R8
   tally_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !inc && !clr) |-> (cnt != '0));
endmodule

// File: rtl/rxq_flags.sv
module rxq_flags #(
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             ovr_evt,
   input  logic             ovr_clr,
   input  logic [CNT_W-1:0] level,
   input  logic [CNT_W-1:0] trig_lvl,
   input  logic             irq_en,
   input  logic [CNT_W-1:0] err_cnt,
   input  logic [CNT_W-1:0] eof_cnt,
   output logic             ovr_flag,
   output logic             irq,
   output logic             dma_req
);
   logic trig_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ovr_flag <= 1'b0;
      else if (clr)     ovr_flag <= 1'b0;
      else if (ovr_evt) ovr_flag <= 1'b1;
      else if (ovr_clr) ovr_flag <= 1'b0;
   end

   assign trig_hit = (level != '0) && (level >= trig_lvl);
   assign dma_req  = trig_hit && (err_cnt == '0);
   assign irq      = irq_en && (trig_hit || (eof_cnt != '0) || ovr_flag);

   // R6
   ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_flag && !ovr_clr && !clr) |=> ovr_flag);
endmodule

// File: rtl/rxq_tagged_fifo.sv
module rxq_tagged_fifo
   import rxq_pkg::*;
#(
   parameter int DEPTH = 64,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              wr_en,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              wr_eof,
   input  logic              wr_crcerr,
   input  logic              rd_en,
   output logic [BYTE_W-1:0] rd_data,
   output logic              rd_eof,
   output logic              rd_crcerr,
   output logic              empty,
   output logic              full,
   output logic [CNT_W-1:0]  level,
   input  logic [CNT_W-1:0]  trig_lvl,
   input  logic              irq_en,
   input  logic              ovr_clr,
   output logic              ovr_flag,
   output logic              irq,
   output logic              dma_req
);
   localparam int N_TAGS = 2;

   rxq_entry_t       wr_ent, rd_ent;
   logic             push, pop, ovr_evt;
   logic [CNT_W-1:0] tag_cnt [N_TAGS];
   logic [N_TAGS-1:0] tag_in, tag_out;

   assign empty   = (level == '0);
   assign full    = (level == CNT_W'(DEPTH));
   assign pop     = rd_en && !empty;
   assign push    = wr_en && (!full || pop);
   assign ovr_evt = wr_en && full && !rd_en;

   assign wr_ent = '{eof: wr_eof, crc_err: wr_crcerr, data: wr_data};

   rxq_store #(.DEPTH(DEPTH)) u_store (
      .clk(clk), .rst_n(rst_n), .clr(clr), .push(push), .pop(pop),
      .wr_ent(wr_ent), .rd_ent(rd_ent), .count(level)
   );

   assign rd_data   = rd_ent.data;
   assign rd_eof    = rd_ent.eof;
   assign rd_crcerr = rd_ent.crc_err;

   assign tag_in  = {wr_eof, wr_crcerr};
   assign tag_out = {rd_ent.eof, rd_ent.crc_err};

   generate
      for (genvar t = 0; t < N_TAGS; t++) begin : g_tag
         rxq_tally #(.CNT_W(CNT_W)) u_tally (
            .clk(clk), .rst_n(rst_n), .clr(clr),
            .inc(push && tag_in[t]), .dec(pop && tag_out[t]),
            .cnt(tag_cnt[t])
         );
      end
   endgenerate

   rxq_flags #(.CNT_W(CNT_W)) u_flags (
      .clk(clk), .rst_n(rst_n), .clr(clr), .ovr_evt(ovr_evt),
      .ovr_clr(ovr_clr), .level(level), .trig_lvl(trig_lvl),
      .irq_en(irq_en), .err_cnt(tag_cnt[0]), .eof_cnt(tag_cnt[1]),
      .ovr_flag(ovr_flag), .irq(irq), .dma_req(dma_req)
   );

   // R4
   ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && full && !rd_en && !clr) |=> ((level == $past(level)) && ovr_flag));

   // R5
   full_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && rd_en && full && !clr && !ovr_flag && !ovr_clr) |=> (full && !ovr_flag));

   // R1
   clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (empty && !ovr_flag && !irq && !dma_req));

   // R8
   dma_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req |-> !empty);
endmodule

// File: tb/tb_rxq_tagged_fifo.sv
module tb_rxq_tagged_fifo;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 8;
   localparam int CW = $clog2(DEPTH + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          clr = 1'b0, wr_en = 1'b0, wr_eof = 1'b0, wr_crcerr = 1'b0;
   logic          rd_en = 1'b0, irq_en = 1'b0, ovr_clr = 1'b0;
   logic [7:0]    wr_data = '0;
   logic [CW-1:0] trig_lvl = '0;
   logic [7:0]    rd_data;
   logic          rd_eof, rd_crcerr, empty, full, ovr_flag, irq, dma_req;
   logic [CW-1:0] level;

   int checks = 0;
   int failures = 0;
   logic [9:0] mq[$];
   logic       m_ovr = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   rxq_tagged_fifo #(.DEPTH(DEPTH)) dut (
      .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en), .wr_data(wr_data),
      .wr_eof(wr_eof), .wr_crcerr(wr_crcerr), .rd_en(rd_en), .rd_data(rd_data),
      .rd_eof(rd_eof), .rd_crcerr(rd_crcerr), .empty(empty), .full(full),
      .level(level), .trig_lvl(trig_lvl), .irq_en(irq_en), .ovr_clr(ovr_clr),
      .ovr_flag(ovr_flag), .irq(irq), .dma_req(dma_req)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   function automatic int tag_count(input int bit_idx);
      int n = 0;
      foreach (mq[i]) if (mq[i][bit_idx]) n++;
      return n;
   endfunction

   function automatic logic exp_trig();
      return (mq.size() != 0) && (mq.size() >= int'(trig_lvl));
   endfunction

   task automatic check_state();
      logic t;
      t = exp_trig();
      check("R11 level", 32'(level), 32'(mq.size()));
      check("R11 empty", 32'(empty), 32'(mq.size() == 0));
      check("R11 full", 32'(full), 32'(mq.size() == DEPTH));
      check("R4 ovr_flag", 32'(ovr_flag), 32'(m_ovr));
      check("R8 dma_req", 32'(dma_req), 32'(t && tag_count(8) == 0));
      check("R9 irq", 32'(irq), 32'(irq_en && (t || tag_count(9) != 0 || m_ovr)));
   endtask

   task automatic step(input logic w, input logic [7:0] d, input logic e, input logic c,
                       input logic r, input logic cl, input logic oc);
      logic set_ovr, do_pop;
      @(negedge clk);
      wr_en = w; wr_data = d; wr_eof = e; wr_crcerr = c;
      rd_en = r; clr = cl; ovr_clr = oc;
      #1;
      if (mq.size() != 0) begin
         check("R2 rd_data", 32'(rd_data), 32'(mq[0][7:0]));
         check("R2 rd_tags", 32'({rd_eof, rd_crcerr}), 32'(mq[0][9:8]));
      end
      @(posedge clk);
      if (cl) begin
         mq.delete();
         m_ovr = 1'b0;
      end else begin
         set_ovr = w && (mq.size() == DEPTH) && !r;
         do_pop = r && (mq.size() != 0);
         if (do_pop) void'(mq.pop_front());
         if (w && !set_ovr) mq.push_back({e, c, d});
         if (set_ovr) m_ovr = 1'b1;
         else if (oc) m_ovr = 1'b0;
      end
      #1;
      check_state();
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      failures++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      check("R1 reset empty", 32'(empty), 32'd1);
      check("R1 reset level", 32'(level), 32'd0);
      check("R1 reset irq/dma/ovr", 32'({irq, dma_req, ovr_flag, full}), 32'd0);
      rst_n = 1'b1;

      // R2 pop on empty ignored
      step(0, 8'h00, 0, 0, 1, 0, 0);
      check("R2 empty pop", 32'(level), 32'd0);

      // R3 R11 fill to full in order; threshold 4, interrupts on
      irq_en = 1'b1;
      trig_lvl = CW'(4);
      for (int i = 0; i < DEPTH; i++) step(1, 8'h10 + 8'(i), 0, 0, 0, 0, 0);
      check("R11 full after fill", 32'(full), 32'd1);
      check("R7 trigger dma", 32'(dma_req), 32'd1);

      // R4 overrun: dropped, contents unchanged, sticky
      step(1, 8'hEE, 0, 0, 0, 0, 0);
      check("R4 ovr set", 32'(ovr_flag), 32'd1);
      step(1, 8'hEF, 1, 1, 0, 0, 0);
      check("R4 level held", 32'(level), 32'(DEPTH));

      // R6 clear and set in same cycle: set wins
      step(1, 8'hF0, 0, 0, 0, 0, 1);
      check("R6 set wins", 32'(ovr_flag), 32'd1);
      step(0, 8'h00, 0, 0, 0, 0, 1);
      check("R6 cleared", 32'(ovr_flag), 32'd0);

      // R5 push+pop at full
      step(1, 8'hA5, 0, 0, 1, 0, 0);
      check("R5 no ovr", 32'(ovr_flag), 32'd0);
      check("R5 still full", 32'(full), 32'd1);

      // R8 checksum-tagged entry blocks DMA until popped
      step(0, 8'h00, 0, 0, 1, 0, 0);
      step(1, 8'h5A, 0, 1, 0, 0, 0);
      check("R8 dma blocked", 32'(dma_req), 32'd0);
      for (int i = 0; i < DEPTH; i++) step(0, 8'h00, 0, 0, 1, 0, 0);
      check("R2 drained", 32'(empty), 32'd1);

      // R9 eof present raises irq below threshold; irq_en gating
      step(1, 8'h77, 1, 0, 0, 0, 0);
      check("R9 eof irq", 32'(irq), 32'd1);
      irq_en = 1'b0;
      #1;
      check("R9 irq disabled", 32'(irq), 32'd0);
      irq_en = 1'b1;

      // R7 threshold zero treated as any nonzero level
      trig_lvl = '0;
      step(0, 8'h00, 1, 0, 1, 0, 0);
      check("R7 empty no trig", 32'(dma_req), 32'd0);

      // R10 clr beats write
      step(1, 8'h33, 0, 0, 0, 0, 0);
      step(1, 8'h44, 0, 0, 0, 1, 0);
      check("R10 clr priority", 32'(level), 32'd0);
      check("R1 clr flags", 32'({irq, dma_req, ovr_flag}), 32'd0);

      // random phase
      trig_lvl = CW'(3);
      for (int n = 0; n < 4000; n++) begin
         if (($urandom % 64) == 0) trig_lvl = CW'($urandom % (DEPTH + 1));
         if (($urandom % 64) == 0) irq_en = 1'($urandom);
         step(($urandom % 10) < 6, 8'($urandom), ($urandom % 6) == 0,
              ($urandom % 8) == 0, ($urandom % 2) == 0,
              ($urandom % 300) == 0, ($urandom % 20) == 0);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule